// File: doc/BRIEF.md
# Partial Reconfiguration Sequencing Controller

This block carries out one complete reconfiguration of a reconfigurable region. A start command supplies the memory address where the configuration image begins and the number of 32-bit words it holds. The controller first asks the module in the region to pause, using an active-low request that the module answers with an active-low acknowledge. The module may take any number of cycles to answer.

Once the acknowledge arrives, the controller reads the image word by word through a memory read port that it shares with application traffic. A grant signal tells the controller when it may use that port. While the application side holds the memory, the grant stays low, and the controller keeps its request and address steady until the grant returns. Each word that memory returns is presented on the configuration data output for one cycle with an active-low chip select. The last word of the image is the desynchronise command.

After the last word, the controller holds the region in reset for a fixed number of cycles. This clears any state the module picked up while it was being rewritten. The controller then releases the reset, withdraws the pause request and signals completion with a one-cycle pulse.

Top module: `pr_seq_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle: busy_o, done_o and mem_req_o are 0, and unload_req_n_o, region_rst_n_o and cfg_cs_n_o are 1.
- R2: A start_i pulse while idle drives unload_req_n_o to 0 and busy_o to 1 in the cycle after the clock edge that samples it.
- R3: While unload_ack_n_i stays 1, the controller issues no memory request. It keeps unload_req_n_o at 0 for as long as the module needs.
- R4: After the acknowledge, the controller reads addresses base, base+1, up to base+count-1, in that order. Each word returned with mem_rvalid_i appears on cfg_data_o, with cfg_cs_n_o at 0, in the cycle after the rvalid cycle.
- R5: cfg_cs_n_o is 0 for exactly one cycle per word read, so it is low for exactly count cycles. It is 1 in every other cycle, including memory-latency cycles and cycles without a grant.
- R6: The controller has at most one read in flight. A request that is not granted (mem_gnt_i at 0, because the application holds memory) is held with an unchanged address until a grant arrives.
- R7: region_rst_n_o goes to 0 in the cycle after the last chip-select cycle and stays 0 for exactly RST_CYCLES consecutive cycles. unload_req_n_o stays 0 during this time.
- R8: In the cycle after the region reset is released, done_o is 1 for one cycle and unload_req_n_o returns to 1. busy_o is 0 in the following cycle.
- R9: A start_i pulse while busy is ignored. The running reconfiguration keeps its original base address and word count, and it produces exactly one done pulse.
- R10: A word count of zero issues no memory request and no chip select. It goes from the acknowledge straight to the region reset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one reconfiguration (accepted only when idle) |
| base_addr_i | input | ADDR_W | First memory word address of the image |
| word_cnt_i | input | CNT_W | Number of image words |
| busy_o | output | 1 | Reconfiguration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request to shared memory |
| mem_addr_o | output | ADDR_W | Read address |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cfg_data_o | output | 32 | Configuration word to the configuration port |
| cfg_cs_n_o | output | 1 | Active-low chip select, low for one cycle per word |
| unload_req_n_o | output | 1 | Active-low pause request to the region module |
| unload_ack_n_i | input | 1 | Active-low pause acknowledge from the region module |
| region_rst_n_o | output | 1 | Active-low reset to the region |

## Verification
The embedded assertions check several properties on every cycle. They check that the idle outputs are quiet, that no memory request is made without an acknowledge, that an ungranted request is held with a stable address, that every chip-select cycle consumes exactly one word of the count, that the region reset is asserted only once the transfer has drained, and that done is a single-cycle pulse. Other behaviour can only be shown by the bench scenarios: the content and order of the configuration words, the exact length of the reset window and where it sits relative to the last word, the wait for a slow acknowledge, and the rejection of a second start. The bench drives these with different memory latencies, grant blocking by application traffic, and a zero-length image.

// File: rtl/pr_seq_pkg.sv
// Shared types for the reconfiguration sequencing controller.
package pr_seq_pkg;

    // Sequencing phases of one reconfiguration.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PAUSE = 3'd1,
        ST_XFER  = 3'd2,
        ST_RESET = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pr_seq_fsm.sv
// Phase sequencer: idle -> pause handshake -> transfer -> region reset -> done.
// Assumes the fetch unit reports xfer_done_i once every word has been strobed,
// and that the reset timer reports expired_i when its hold window has ended.
module pr_seq_fsm
    import pr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_n_i,
    input  logic xfer_done_i,
    input  logic expired_i,
    output logic accept_o,
    output logic xfer_en_o,
    output logic rst_load_o,
    output logic busy_o,
    output logic done_o,
    output logic req_n_o,
    output logic region_rst_n_o
);

    seq_state_t state_q, state_d;

    assign accept_o   = (state_q == ST_IDLE) && start_i;
    assign xfer_en_o  = (state_q == ST_XFER);
    assign rst_load_o = (state_q == ST_XFER) && xfer_done_i;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)     state_d = ST_PAUSE;
            ST_PAUSE: if (!ack_n_i)    state_d = ST_XFER;
            ST_XFER:  if (xfer_done_i) state_d = ST_RESET;
            ST_RESET: if (expired_i)   state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered phase.
    always_comb begin
        busy_o         = (state_q != ST_IDLE);
        done_o         = (state_q == ST_DONE);
        req_n_o        = !((state_q == ST_PAUSE) || (state_q == ST_XFER) ||
                           (state_q == ST_RESET));
        region_rst_n_o = (state_q != ST_RESET);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && ack_n_i) |=> !req_n_o); // R3

endmodule

// File: rtl/pr_seq_fetch.sv
// Configuration word fetcher: issues one memory read at a time, holds an
// ungranted request steady, and registers each returned word onto the
// configuration port with a one-cycle active-low chip select.
// Assumes mem_rvalid_i is only meaningful while a read is in flight.
module pr_seq_fetch #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              en_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_cs_n_o,
    output logic              done_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic              inflight_q;
    logic              take;

    assign take       = inflight_q && mem_rvalid_i;
    assign mem_req_o  = en_i && (remain_q != '0) && !inflight_q;
    assign mem_addr_o = addr_q;
    assign done_o     = (remain_q == '0) && !inflight_q;

    // Address, remaining count and in-flight tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            remain_q   <= '0;
            inflight_q <= 1'b0;
        end else if (load_i) begin
            addr_q     <= base_i;
            remain_q   <= count_i;
            inflight_q <= 1'b0;
        end else begin
            if (mem_req_o && mem_gnt_i) begin
                inflight_q <= 1'b1;
                addr_q     <= addr_q + ADDR_W'(1);
            end
            if (take) begin
                inflight_q <= 1'b0;
                remain_q   <= remain_q - CNT_W'(1);
            end
        end
    end

    // Configuration port register: one strobe per returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_data_o <= '0;
            cfg_cs_n_o <= 1'b1;
        end else begin
            cfg_cs_n_o <= !take;
            if (take) cfg_data_o <= mem_rdata_i;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i && !load_i) |=> (mem_req_o && $stable(mem_addr_o))); // R6
    AST_STROBE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cs_n_o |-> ($past(remain_q) == remain_q + CNT_W'(1))); // R5
    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !mem_req_o); // R6

endmodule

// File: rtl/pr_seq_rst_timer.sv
// Region reset hold timer: loaded on entry to the reset phase, counts down
// to zero; expired_o marks the last cycle of the hold window.
// Assumes HOLD is at least 1.
module pr_seq_rst_timer #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam int TW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == '0);

    // Down-counter over the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= TW'(HOLD - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
    end

endmodule

// File: rtl/pr_seq_ctrl.sv
// Top of the partial reconfiguration sequencing controller. Connects the
// phase sequencer, the configuration word fetcher and the reset timer.
// Assumes the shared memory arbitrates externally and signals use by the
// application side by withholding mem_gnt_i.
module pr_seq_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic [31:0]       cfg_data_o,
    output logic              cfg_cs_n_o,
    output logic              unload_req_n_o,
    input  logic              unload_ack_n_i,
    output logic              region_rst_n_o
);

    localparam int DATA_W = 32;

    logic accept, xfer_en, rst_load, xfer_done, expired;

    pr_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .ack_n_i        (unload_ack_n_i),
        .xfer_done_i    (xfer_done),
        .expired_i      (expired),
        .accept_o       (accept),
        .xfer_en_o      (xfer_en),
        .rst_load_o     (rst_load),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .req_n_o        (unload_req_n_o),
        .region_rst_n_o (region_rst_n_o)
    );

    pr_seq_fetch #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .base_i       (base_addr_i),
        .count_i      (word_cnt_i),
        .en_i         (xfer_en),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_gnt_i    (mem_gnt_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .cfg_data_o   (cfg_data_o),
        .cfg_cs_n_o   (cfg_cs_n_o),
        .done_o       (xfer_done)
    );

    pr_seq_rst_timer #(
        .HOLD (RST_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (rst_load),
        .expired_o (expired)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (unload_req_n_o && region_rst_n_o && !mem_req_o && !done_o)); // R1
    AST_NO_FETCH_UNPAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !unload_req_n_o); // R3
    AST_RESET_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !region_rst_n_o |-> (xfer_done && !mem_req_o && !unload_req_n_o)); // R7

endmodule

// File: tb/pr_seq_ctrl_tb.sv
// Self-checking bench for pr_seq_ctrl: table-driven reconfigurations, then
// directed cases for reset state, slow acknowledge, second start and zero count.
module pr_seq_ctrl_tb;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;
    localparam int RSTC   = 4;

    typedef struct packed {
        logic [15:0] base;
        logic [11:0] cnt;
        logic [3:0]  lat;
        logic        stall;
        logic [7:0]  ackd;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{base: 16'h0100, cnt: 12'd6,  lat: 4'd1, stall: 1'b0, ackd: 8'd0},
        '{base: 16'h0400, cnt: 12'd9,  lat: 4'd3, stall: 1'b0, ackd: 8'd3},
        '{base: 16'h1FF0, cnt: 12'd12, lat: 4'd2, stall: 1'b1, ackd: 8'd1},
        '{base: 16'hFFFE, cnt: 12'd4,  lat: 4'd1, stall: 1'b1, ackd: 8'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [CNT_W-1:0]  cnt = '0;
    logic busy, done, mem_req, cs_n, req_n, region_rst_n;
    logic [ADDR_W-1:0] mem_addr;
    logic gnt = 1'b1;
    logic rvalid = 1'b0;
    logic [31:0] rdata = '0;
    logic [31:0] cfg_data;
    logic ack_n = 1'b1;

    always #2.5 clk = ~clk;

    pr_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
        .word_cnt_i(cnt), .busy_o(busy), .done_o(done), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_gnt_i(gnt), .mem_rvalid_i(rvalid),
        .mem_rdata_i(rdata), .cfg_data_o(cfg_data), .cfg_cs_n_o(cs_n),
        .unload_req_n_o(req_n), .unload_ack_n_i(ack_n), .region_rst_n_o(region_rst_n)
    );

    int total = 0;
    int bad = 0;

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a, ~a} ^ 32'hC3A5_0F1E;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: one read, fixed latency, data from mem_word.
    int lat = 1;
    bit stall = 1'b0;
    int cyc = 0;
    bit pend = 1'b0;
    int pcnt = 0;
    logic [ADDR_W-1:0] paddr = '0;
    always @(posedge clk) begin
        rvalid <= 1'b0;
        if (pend) begin
            if (pcnt <= 1) begin
                rvalid <= 1'b1;
                rdata  <= mem_word(paddr);
                pend   <= 1'b0;
            end else pcnt <= pcnt - 1;
        end
        if (mem_req && gnt) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            pcnt  <= lat;
        end
    end

    // Grant pattern (application traffic) and acknowledge responder.
    int ack_wait = 0;
    always @(negedge clk) begin
        gnt = !(stall && ((cyc % 5) < 2));
        if (!req_n) begin
            if (ack_wait > 0) ack_wait--;
            else ack_n = 1'b0;
        end else ack_n = 1'b1;
    end

    // Monitor, sampled away from the active edge.
    logic [31:0] cap [64];
    int n_words, last_strobe, rst_first, rst_low, done_n, done_cyc;
    int req_unacked, hold_bad, stall_seen, req_n_bad, busy_after_done, req_n_at_done;
    logic prev_req = 1'b0, prev_gnt = 1'b1, prev_region = 1'b1;
    logic [ADDR_W-1:0] prev_addr = '0;

    task automatic clear_mon();
        n_words = 0; last_strobe = -1; rst_first = -1; rst_low = 0;
        done_n = 0; done_cyc = -1; req_unacked = 0; hold_bad = 0;
        stall_seen = 0; req_n_bad = 0; busy_after_done = -1; req_n_at_done = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!cs_n) begin
                if (n_words < 64) cap[n_words] = cfg_data;
                n_words++;
                last_strobe = cyc;
            end
            if (!region_rst_n) begin
                if (prev_region) rst_first = cyc;
                rst_low++;
                if (req_n) req_n_bad++;
            end
            if (mem_req && ack_n && req_n) req_unacked++;
            if (mem_req && ack_n && $time > 0 && !busy) req_unacked++;
            if (prev_req && !prev_gnt) begin
                stall_seen++;
                if (!mem_req || mem_addr != prev_addr) hold_bad++;
            end
            if (done_cyc >= 0 && cyc == done_cyc + 1) busy_after_done = int'(busy);
            if (done) begin
                done_n++;
                done_cyc = cyc;
                req_n_at_done = int'(req_n);
            end
            prev_region = region_rst_n;
            prev_req = mem_req;
            prev_gnt = gnt;
            prev_addr = mem_addr;
        end
    end

    // Issue start at a falling edge for one cycle and check R2 on the next.
    task automatic kick(input logic [ADDR_W-1:0] b, input logic [CNT_W-1:0] n);
        @(negedge clk);
        base = b; cnt = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req_n == 1'b0 && busy == 1'b1, "R2", "pause request after start",
              {req_n, busy}, 2'b01);
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_n == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_run(input logic [ADDR_W-1:0] b, input int n, input string tag);
        check(done_n == 1, "R9", {tag, " done pulse count"}, done_n, 1);
        check(n_words == n, "R5", {tag, " strobe count"}, n_words, n);
        for (int i = 0; i < n && i < 64; i++) begin
            logic [ADDR_W-1:0] a = b + ADDR_W'(i);
            check(cap[i] == mem_word(a), "R4", {tag, " word"}, cap[i], mem_word(a));
        end
        check(rst_low == RSTC, "R7", {tag, " reset length"}, rst_low, RSTC);
        if (n > 0)
            check(rst_first == last_strobe + 1, "R7", {tag, " reset start"},
                  rst_first, last_strobe + 1);
        check(req_n_bad == 0, "R7", {tag, " request held in reset"}, req_n_bad, 0);
        check(done_cyc == rst_first + RSTC && req_n_at_done == 1, "R8",
              {tag, " done timing"}, done_cyc, rst_first + RSTC);
        check(busy_after_done == 0, "R8", {tag, " busy drop"}, busy_after_done, 0);
        check(req_unacked == 0, "R3", {tag, " fetch before ack"}, req_unacked, 0);
        check(hold_bad == 0, "R6", {tag, " held request"}, hold_bad, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(!busy && !done && !mem_req && req_n && region_rst_n && cs_n, "R1",
              "outputs in reset", {busy, done, mem_req, req_n, region_rst_n, cs_n}, 6'b000111);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && req_n && region_rst_n && cs_n, "R1",
              "idle after reset", {busy, mem_req, req_n, region_rst_n, cs_n}, 5'b00111);

        // Table-driven reconfigurations (R4, R5, R6, R7, R8).
        for (int v = 0; v < NV; v++) begin
            clear_mon();
            lat = int'(VECS[v].lat);
            stall = VECS[v].stall;
            ack_wait = int'(VECS[v].ackd);
            kick(VECS[v].base, VECS[v].cnt);
            wait_done();
            check_run(VECS[v].base, int'(VECS[v].cnt), $sformatf("vec%0d", v));
            if (VECS[v].stall)
                check(stall_seen > 0, "R6", "grant withheld seen", stall_seen, 1);
        end

        // R3: slow acknowledge, no fetch while waiting.
        clear_mon();
        lat = 1; stall = 1'b0; ack_wait = 40;
        kick(16'h0800, 12'd3);
        repeat (30) @(negedge clk);
        check(req_n == 1'b0 && !mem_req && n_words == 0, "R3", "waiting for ack",
              {req_n, mem_req}, 2'b00);
        wait_done();
        check_run(16'h0800, 3, "slowack");

        // R9: a second start during transfer is ignored.
        clear_mon();
        lat = 2; stall = 1'b1; ack_wait = 0;
        kick(16'h0A00, 12'd8);
        repeat (6) @(negedge clk);
        base = 16'h0300; cnt = 12'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_run(16'h0A00, 8, "restart_r9");

        // R10: zero-length image.
        clear_mon();
        lat = 1; stall = 1'b0; ack_wait = 2;
        kick(16'h0C00, 12'd0);
        wait_done();
        check(n_words == 0 && stall_seen == 0, "R10", "no words", n_words, 0);
        check(rst_low == RSTC && done_n == 1, "R10", "reset follows ack", rst_low, RSTC);
        check(busy_after_done == 0, "R8", "zero busy drop", busy_after_done, 0);

        // R1: idle again afterwards.
        check(!busy && req_n && region_rst_n && cs_n && !mem_req, "R1", "final idle",
              {busy, req_n, region_rst_n, cs_n, mem_req}, 5'b01110);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule